// File: doc/BRIEF.md
# Trace FIFO with write-count trigger

This block is a circular store for 64-bit trace records. A producer pushes records in with `wr_en`, and a consumer pops the oldest record with `rd_en`. The block tracks a write pointer, a read pointer and a fill level, and shows all three as status outputs.

A separate write counter counts the records that are accepted. When the counter has seen `trig_level + 1` accepted records since the last trigger, the block emits a one-cycle trigger pulse. The counter then returns to zero on its own. If DMA requests are enabled, the same pulse also appears as a DMA request. The interrupt logic elsewhere turns the trigger pulse into a flag.

A push into a full store raises an overflow pulse. A pop from an empty store raises an underflow pulse. A synchronous clear input zeroes the pointers, the fill level and the write counter.

Top module: `trace_fifo`

## Requirements
- R1: After reset, `wr_ptr`, `rd_ptr`, `level`, `wr_count` and `rd_data` are 0, `empty` is 1, `full` is 0, `trig_level` is 0x3FF, and all four pulse outputs are 0.
- R2: Records are returned in the order they were accepted. `rd_data` takes the popped record at the clock edge where the pop is accepted.
- R3: `level` equals the number of accepted pushes minus the number of accepted pops. A push and a pop in the same cycle on a store that is neither empty nor full leave `level` unchanged.
- R4: The store holds at most 1023 records (`full` when `level` = 1023). A push while full is dropped and `wr_ptr` does not move. `ovf_pulse` is 1 for the one cycle that follows.
- R5: A pop while empty leaves `rd_ptr` and `rd_data` unchanged. `unf_pulse` is 1 for the one cycle that follows.
- R6: `wr_count` counts accepted pushes only. An accepted push while `wr_count` equals `trig_level` returns `wr_count` to 0 and makes `trig_pulse` 1 for the following cycle.
- R7: `dma_req` is 1 in exactly the cycles where `trig_pulse` is 1 and `dma_en` was 1 at the triggering edge. Otherwise it is 0.
- R8: `clr` = 1 sets `wr_ptr`, `rd_ptr`, `level` and `wr_count` to 0 at the next edge. In that cycle it overrides any push or pop, and it leaves `trig_level` and `rd_data` unchanged.
- R9: `lvl_we` = 1 loads `lvl_wdata` into `trig_level` at the edge. A push in that same cycle is compared against the old level.
- R10: `wr_ptr` and `rd_ptr` advance by one per accepted push or pop, modulo 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of pointers, fill level and write counter |
| lvl_we | input | 1 | Load strobe for the trigger level |
| lvl_wdata | input | 10 | New trigger level |
| dma_en | input | 1 | Allows triggers to raise DMA requests |
| wr_en | input | 1 | Push request |
| wr_data | input | 64 | Record to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 64 | Last popped record |
| wr_ptr | output | 10 | Write pointer |
| rd_ptr | output | 10 | Read pointer |
| level | output | 10 | Records waiting to be read |
| wr_count | output | 10 | Accepted pushes since the last trigger |
| trig_level | output | 10 | Current trigger level |
| full | output | 1 | Store holds 1023 records |
| empty | output | 1 | Store holds no records |
| trig_pulse | output | 1 | One-cycle trigger |
| dma_req | output | 1 | One-cycle DMA request |
| ovf_pulse | output | 1 | One-cycle overflow event |
| unf_pulse | output | 1 | One-cycle underflow event |

## Verification
Two functions can land in the same cycle:
- A trigger from an accepted push can coincide with a pop. This is provoked with a trigger level of 2 while pushes and pops are interleaved.
- An overflow can coincide with a successful pop. This is provoked by asserting both requests on a full store, where the pop must succeed while the push is dropped.

In both cases the bench's queue model predicts every output, including `level`, the pointers and the pulses, for each cycle. A clear issued together with a push and a pop shows that the clear takes priority.

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter int DW = 64,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          lvl_we,
  input  logic [AW-1:0] lvl_wdata,
  input  logic          dma_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] level,
  output logic [AW-1:0] wr_count,
  output logic [AW-1:0] trig_level,
  output logic          full,
  output logic          empty,
  output logic          trig_pulse,
  output logic          dma_req,
  output logic          ovf_pulse,
  output logic          unf_pulse
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] CAP = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];

  assign full  = (level == CAP);
  assign empty = (level == '0);

  wire take_w = wr_en & ~full & ~clr;
  wire take_r = rd_en & ~empty & ~clr;
  wire hit    = take_w & (wr_count == trig_level);

  always_ff @(posedge clk)
    if (take_w) mem[wr_ptr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      level      <= '0;
      wr_count   <= '0;
      trig_level <= '1;
      rd_data    <= '0;
      trig_pulse <= 1'b0;
      dma_req    <= 1'b0;
      ovf_pulse  <= 1'b0;
      unf_pulse  <= 1'b0;
    end else begin
      ovf_pulse  <= wr_en & full & ~clr;
      unf_pulse  <= rd_en & empty & ~clr;
      trig_pulse <= hit;
      dma_req    <= hit & dma_en;
      if (lvl_we) trig_level <= lvl_wdata;
      if (clr) begin
        wr_ptr   <= '0;
        rd_ptr   <= '0;
        level    <= '0;
        wr_count <= '0;
      end else begin
        if (take_w) begin
          wr_ptr   <= wr_ptr + 1'b1;
          wr_count <= hit ? '0 : wr_count + 1'b1;
        end
        if (take_r) begin
          rd_ptr  <= rd_ptr + 1'b1;
          rd_data <= mem[rd_ptr];
        end
        level <= level + AW'(take_w) - AW'(take_r);
      end
    end
  end
endmodule

// File: rtl/trace_fifo_chk.sv
module trace_fifo_chk #(
  parameter int DW = 64,
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic [AW-1:0] level,
  input logic [AW-1:0] wr_count,
  input logic [AW-1:0] trig_level,
  input logic          full,
  input logic          empty,
  input logic          trig_pulse,
  input logic          dma_req,
  input logic          ovf_pulse,
  input logic          unf_pulse
);
  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !clr |=> ovf_pulse && $stable(wr_ptr));
  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_en && !clr |=> unf_pulse && $stable(rd_ptr) && $stable(rd_data));
  // R3
  both_ops_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && rd_en && !empty && !full && !clr |=> $stable(level));
  // R3
  level_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level == AW'(wr_ptr - rd_ptr));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> wr_ptr == '0 && rd_ptr == '0 && level == '0 && wr_count == '0);
  // R6
  trig_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !full && !clr && wr_count == trig_level |=> trig_pulse && wr_count == '0);
  // R7
  dma_with_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> trig_pulse);
endmodule

bind trace_fifo trace_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level),
  .wr_count(wr_count), .trig_level(trig_level), .full(full), .empty(empty),
  .trig_pulse(trig_pulse), .dma_req(dma_req), .ovf_pulse(ovf_pulse),
  .unf_pulse(unf_pulse)
);

// File: tb/trace_fifo_test.sv
module trace_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, lvl_we = 1'b0, dma_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]  lvl_wdata = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [9:0]  wr_ptr, rd_ptr, level, wr_count, trig_level;
  logic        full, empty, trig_pulse, dma_req, ovf_pulse, unf_pulse;

  always #4 clk = ~clk;

  trace_fifo uut (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  logic [63:0] q[$];
  int m_wp = 0, m_rp = 0, m_cnt = 0, m_lvl = 1023;
  logic [63:0] m_rd = '0;
  bit m_trig = 0, m_dma = 0, m_ovf = 0, m_unf = 0;

  task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int sz = q.size();
    bit hit = 0;
    m_ovf = 0; m_unf = 0; m_trig = 0; m_dma = 0;
    if (!clr) begin
      m_ovf = wr_en && sz == 1023;
      m_unf = rd_en && sz == 0;
      if (rd_en && sz > 0) begin
        m_rd = q.pop_front();
        m_rp = (m_rp + 1) % 1024;
      end
      if (wr_en && sz < 1023) begin
        q.push_back(wr_data);
        m_wp = (m_wp + 1) % 1024;
        hit = (m_cnt == m_lvl);
        m_cnt = hit ? 0 : m_cnt + 1;
      end
      m_trig = hit;
      m_dma = hit && dma_en;
    end else begin
      q.delete();
      m_wp = 0; m_rp = 0; m_cnt = 0;
    end
    if (lvl_we) m_lvl = int'(lvl_wdata);
  endtask

  task automatic compare();
    chk("R10", "wr_ptr", wr_ptr, m_wp);
    chk("R10", "rd_ptr", rd_ptr, m_rp);
    chk("R3", "level", level, q.size());
    chk("R4", "full", full, q.size() == 1023);
    chk("R5", "empty", empty, q.size() == 0);
    chk("R2", "rd_data", rd_data, m_rd);
    chk("R4", "ovf_pulse", ovf_pulse, m_ovf);
    chk("R5", "unf_pulse", unf_pulse, m_unf);
    chk("R6", "wr_count", wr_count, m_cnt);
    chk("R6", "trig_pulse", trig_pulse, m_trig);
    chk("R7", "dma_req", dma_req, m_dma);
    chk("R9", "trig_level", trig_level, m_lvl);
  endtask

  task automatic step(bit w, bit r, bit c = 0);
    wr_en = w; rd_en = r; clr = c;
    wr_data = {$urandom, $urandom};
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    lvl_we = 0; clr = 0;
  endtask

  task automatic set_lvl(int v);
    lvl_we = 1; lvl_wdata = 10'(v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "wr_ptr", wr_ptr, 0);
    chk("R1", "rd_ptr", rd_ptr, 0);
    chk("R1", "level", level, 0);
    chk("R1", "wr_count", wr_count, 0);
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "trig_level", trig_level, 10'h3FF);
    chk("R1", "rd_data", rd_data, 0);
    chk("R1", "pulses", {trig_pulse, dma_req, ovf_pulse, unf_pulse}, 0);

    // R9/R6/R7: trigger every 3 writes with DMA on
    dma_en = 1; set_lvl(2);
    step(0, 0);
    for (int i = 0; i < 7; i++) step(1, 0);
    for (int i = 0; i < 3; i++) step(0, 1);
    // R3: concurrent push and pop, triggers interleaved
    for (int i = 0; i < 10; i++) step(1, 1);
    // R5: drain then underflow, also pop+push on empty
    while (q.size() > 0) step(0, 1);
    step(0, 1); step(0, 1); step(1, 1); step(0, 1);
    // R6/R7: level 0, DMA off
    dma_en = 0; set_lvl(0); step(0, 0);
    for (int i = 0; i < 4; i++) step(1, 0);
    // R9: load while pushing uses old level
    set_lvl(1023); step(1, 0);
    // R4: fill and overflow
    while (q.size() < 1023) step(1, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    for (int i = 0; i < 4; i++) step(1, 1);
    dma_en = 1;
    // R10: drain across wrap
    while (q.size() > 0) step(0, 1);
    for (int i = 0; i < 20; i++) step(1, (i % 3) == 0);
    // R8: clear with push and pop asserted
    set_lvl(5);
    step(1, 1, 1);
    chk("R8", "wr_ptr after clr", wr_ptr, 0);
    chk("R8", "rd_ptr after clr", rd_ptr, 0);
    chk("R8", "level after clr", level, 0);
    chk("R8", "wr_count after clr", wr_count, 0);
    chk("R8", "trig_level after clr", trig_level, 5);
    // mixed traffic
    for (int i = 0; i < 2000; i++) begin
      if (i % 97 == 0) set_lvl(int'($urandom_range(0, 7)));
      step($urandom_range(0, 2) != 0, $urandom_range(0, 2) == 0, i == 1500);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule